// File: doc/BRIEF.md
# Pass-Gated Twiddle Index Sequencer

This block supplies the twiddle-factor ROM address stream for a 256-point radix-2 transform engine that runs eight passes over its data. A free-running binary step counter produces the low bits of the address. Each counter value is ANDed with a pass mask held in a shift register. In the first pass the mask keeps only bit 0. At every pass boundary one more low-order bit of the mask is set. Early passes therefore touch only a few twiddle entries, and each later pass reaches a finer set. There is no multiplier and no stride arithmetic.

The address and the pass number leave the block through registers. The downstream ROM then sees a clean clock-to-output path rather than the counter-and-mask logic. A one-cycle start pulse launches a run, and a pipeline enable allows the surrounding datapath to stall it. The block reports `busy` while the run is in progress and holds `done` once the last pass has finished.

The controller has three states. ST_IDLE is the state after reset. ST_RUN steps the counter on each enabled cycle. ST_DONE holds until the next start. It has three transitions:
- launch: ST_IDLE to ST_RUN, when `start` is high.
- finish: ST_RUN to ST_DONE, on the enabled cycle in which the counter sits at 255 and the mask is all ones.
- relaunch: ST_DONE to ST_RUN, when `start` is high.

Top module: `twiddle_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `busy`, `done`, `addr_valid`, `tw_addr` and `pass_idx` are all 0.
- R2: A `start` pulse in ST_IDLE or ST_DONE raises `busy` at the next clock edge, and it also clears the step count k to 0.
- R3: Step k is the k-th enabled cycle in ST_RUN, counting from 0. One clock edge after step k, `tw_addr` equals (k mod 256) AND M. Here M is an 8-bit mask whose bits 0 to p are set and whose other bits are clear, with p = k div 256.
- R4: The mask gains one more low-order set bit after every 256 steps, starting from 8'b00000001. `pass_idx` is output together with each address and equals the number of set mask bits minus one, so it runs through 0 to 7.
- R5: A cycle with `en` low leaves the counter and the mask unchanged. At the following edge `addr_valid` is 0 and `tw_addr` holds its previous value.
- R6: After step 2047 is taken, `busy` falls and `done` rises at the same edge. `done` then stays high and `addr_valid` stays low until the next start.
- R7: A `start` pulse while `busy` is high has no effect. The address sequence continues unchanged.
- R8: A `start` pulse in ST_DONE clears `done` and begins a new run whose first address is 0 in pass 0.
- R9: `addr_valid` is high exactly on the cycle after each step, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run (ignored while busy) |
| en | input | 1 | Pipeline enable; a step is taken only when high |
| tw_addr | output | 8 | Registered twiddle ROM address |
| pass_idx | output | 3 | Registered pass number belonging to `tw_addr` |
| addr_valid | output | 1 | High on the cycle after a step |
| busy | output | 1 | High while in ST_RUN |
| done | output | 1 | High in ST_DONE |

## Verification
The bench drives two complete runs and checks every one of the 2048 addresses, together with its pass number, against values computed arithmetically from the step index.

The first run has irregular stall gaps and a stray start pulse partway through. The gaps distinguish a counter that advances only on enabled cycles from one that runs freely. The stray pulse shows whether a start during a run can reset the sequence.

The second run begins from ST_DONE with `en` held high throughout. It exercises the relaunch path and the behaviour at each pass boundary without stalls. Idle cycles after each run confirm that `done` holds and that no valid address appears.

// File: rtl/twg_pkg.sv
package twg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } twg_state_e;
endpackage

// File: rtl/twg_ctrl.sv
module twg_ctrl
    import twg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       en,
    input  logic       last_step,
    output twg_state_e state,
    output logic       clear,
    output logic       step,
    output logic       busy,
    output logic       done
);
    twg_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_RUN;
            ST_RUN:  if (en && last_step) state_nxt = ST_DONE;
            ST_DONE: if (start) state_nxt = ST_RUN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        clear = 1'b0;
        step  = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_IDLE: clear = start;
            ST_RUN: begin
                busy = 1'b1;
                step = en;
            end
            ST_DONE: begin
                done  = 1'b1;
                clear = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/twg_counter.sv
module twg_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = &cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twg_mask.sv
module twg_mask #(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [W-1:0]  mask,
    output logic          full,
    output logic [PW-1:0] pass
);
    localparam int CW = $clog2(W + 1);
    logic [CW-1:0] ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= W'(1);
        else if (clear)   mask <= W'(1);
        else if (advance) mask <= {mask[W-2:0], 1'b1};
    end

    assign full = &mask;

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) ones = ones + CW'(mask[i]);
        pass = PW'(ones - CW'(1));
    end
endmodule

// File: rtl/twiddle_addr_gen.sv
module twiddle_addr_gen
    import twg_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          en,
    output logic [W-1:0]  tw_addr,
    output logic [PW-1:0] pass_idx,
    output logic          addr_valid,
    output logic          busy,
    output logic          done
);
    twg_state_e    state;
    logic          clear, step, wrap, full, last_step;
    logic [W-1:0]  cnt, mask;
    logic [PW-1:0] pass;

    assign last_step = wrap && full;

    twg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .en(en),
        .last_step(last_step), .state(state), .clear(clear),
        .step(step), .busy(busy), .done(done)
    );

    twg_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .cnt(cnt), .wrap(wrap)
    );

    twg_mask #(.W(W), .PW(PW)) u_mask (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .advance(step && wrap && !full),
        .mask(mask), .full(full), .pass(pass)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_addr    <= '0;
            pass_idx   <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= step;
            if (step) begin
                tw_addr  <= cnt & mask;
                pass_idx <= pass;
            end
        end
    end
endmodule

// File: rtl/twg_checker.sv
module twg_checker #(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [W-1:0]  tw_addr,
    input logic [PW-1:0] pass_idx,
    input logic          addr_valid,
    input logic          busy,
    input logic          done
);
    logic [W-1:0] allowed;
    always_comb begin
        for (int i = 0; i < W; i++) allowed[i] = (i <= int'(pass_idx));
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !en) |=> (!addr_valid && $stable(tw_addr))); // R5
    AST_ADDR_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n) addr_valid |-> ((tw_addr & ~allowed) == '0)); // R3
    AST_STALL_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !en) |=> busy); // R7
    AST_PASS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n) (busy && addr_valid) |=> (!addr_valid || pass_idx >= $past(pass_idx))); // R4
    AST_DONE_LAST_PASS: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> (pass_idx == PW'(W - 1))); // R6
    AST_VALID_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) (!busy) |=> !addr_valid); // R9
endmodule

bind twiddle_addr_gen twg_checker #(.W(W), .PW(PW)) u_twg_checker (
    .clk(clk), .rst_n(rst_n), .en(en), .tw_addr(tw_addr),
    .pass_idx(pass_idx), .addr_valid(addr_valid), .busy(busy), .done(done)
);

// File: tb/twiddle_addr_gen_test.sv
`timescale 1ns/1ps
module twiddle_addr_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       en = 1'b0;
    logic [7:0] tw_addr;
    logic [2:0] pass_idx;
    logic       addr_valid, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    bit m_run = 0, m_done = 0, e_valid = 0;
    int m_k = 0, e_addr = 0, e_pass = 0;
    bit tag_r7 = 0;

    always #2.5 clk = ~clk;

    twiddle_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .en(en),
        .tw_addr(tw_addr), .pass_idx(pass_idx), .addr_valid(addr_valid),
        .busy(busy), .done(done)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (k=%0d)", tag, got, exp, m_k);
        end
    endtask

    task automatic cycle(input bit en_v, input bit start_v);
        int prev_addr;
        @(negedge clk);
        en = en_v;
        start = start_v;
        prev_addr = tw_addr;
        @(posedge clk);
        if (!m_run && start_v) begin
            m_run = 1; m_done = 0; m_k = 0; e_valid = 0;
        end else if (m_run && en_v) begin
            e_valid = 1;
            e_pass = m_k / 256;
            e_addr = (m_k % 256) & ((1 << (e_pass + 1)) - 1);
            m_k++;
            if (m_k == 2048) begin m_run = 0; m_done = 1; end
        end else begin
            e_valid = 0;
        end
        #1;
        check("R9 addr_valid", addr_valid, e_valid);
        check("R2 busy", busy, m_run);
        check("R6 done", done, m_done);
        if (e_valid) begin
            check(tag_r7 ? "R7 tw_addr" : "R3 tw_addr", tw_addr, e_addr);
            check("R4 pass_idx", pass_idx, e_pass);
            tag_r7 = 0;
        end else if (m_run || m_done) begin
            check("R5 tw_addr hold", tw_addr, prev_addr);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 addr_valid", addr_valid, 0);
        check("R1 tw_addr", tw_addr, 0);
        check("R1 pass_idx", pass_idx, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b1, 1'b0);
        check("R1 idle busy", busy, 0);

        // Run 1: stalls and a stray start (R2, R3, R4, R5, R7)
        cycle(1'b0, 1'b1);
        for (int i = 0; m_run; i++) begin
            bit st;
            st = (i == 700);
            if (st) tag_r7 = 1;
            cycle(!((i % 7) == 3 || (i % 11) == 5), st);
        end
        // R6: done holds, no valid
        for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0);
        check("R6 done hold", done, 1);

        // Run 2: relaunch from done, en always high (R8)
        cycle(1'b1, 1'b1);
        check("R8 done cleared", done, 0);
        check("R8 busy", busy, 1);
        cycle(1'b1, 1'b0);
        check("R8 first addr", tw_addr, 0);
        check("R8 first pass", pass_idx, 0);
        while (m_run) cycle(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule